// File: doc/BRIEF.md
# Pushbutton-Stepped One-Hot Channel Selector

This block turns a single mechanical pushbutton into a four-way one-hot select bus that drives the enable pins of an external stereo analog switch. The raw button is brought into the clock domain by a two-flop synchronizer. A four-state debounce machine then cleans it and emits a one-cycle press event on each accepted press. The state machine has four states:

- `DB_RELEASED`: the button is stable low.
- `DB_RISE_WAIT`: a rise is being timed.
- `DB_HELD`: the button is stable high.
- `DB_FALL_WAIT`: a fall is being timed.

It has six transitions:

- *rise seen*: `DB_RELEASED` to `DB_RISE_WAIT`.
- *rise rejected*: `DB_RISE_WAIT` back to `DB_RELEASED`.
- *press accepted*: `DB_RISE_WAIT` to `DB_HELD`. This transition emits the press event.
- *fall seen*: `DB_HELD` to `DB_FALL_WAIT`.
- *fall rejected*: `DB_FALL_WAIT` back to `DB_HELD`.
- *release accepted*: `DB_FALL_WAIT` to `DB_RELEASED`.

Each press event steps a counter made of two toggle stages. The low stage flips on every press. The high stage flips only when the low stage falls from 1 to 0. A NOR-style decoder, registered at the output, turns the two-bit count into exactly one active select line. A synchronous reset always returns the selector to channel 1.

Top module: `chan_stepper`

## Requirements
- R1: Outside reset, exactly one bit of `sel_o` is high at every clock. `sel_o[3]` enables channel 1, `sel_o[2]` channel 2, `sel_o[1]` channel 3 and `sel_o[0]` channel 4.
- R2: One clock after `rst_i` is sampled high, `sel_o` is 4'b1000 and `chan_idx_o` is 0, whatever the previous channel was.
- R3: Each accepted press moves the selection one step through the order 4'b1000, 4'b0100, 4'b0010, 4'b0001.
- R4: A press while `sel_o` is 4'b0001 returns the selection to 4'b1000.
- R5: `chan_idx_o` equals the channel number minus one. Its bit 0 (the low stage) flips on every accepted press. Its bit 1 (the high stage) flips only on presses where bit 0 goes from 1 to 0. It changes on the same clock edge as `sel_o`.
- R6: Releasing the button never changes `sel_o` or `chan_idx_o`.
- R7: A press held high for any length of time advances the selection exactly once.
- R8: `btn_i` is active high. A level is accepted only after the synchronized button has held it for more than `DEBOUNCE_CYCLES` consecutive clocks. Shorter pulses and contact bounce cause no step, so a bouncing press still counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Raw asynchronous pushbutton level, high while pressed |
| sel_o | output | 4 | Registered one-hot channel enables, bit 3 = channel 1 |
| chan_idx_o | output | 2 | Registered channel index, 0 = channel 1 |

## Verification
A corrupted toggle stage shows at the ports within two clocks of the press that exposes it. Depending on which stage is wrong, the selection skips a channel, repeats one, or fails to wrap. A debounce machine stuck in a wait state or holding a stale count shows up instead as a missing step, or a doubled step, after a bouncing press, a short glitch or a long hold. The bench predicts each pattern before it drives a press. It then treats any port change it did not predict, or any missing change, as an error.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
    localparam int unsigned CHAN_COUNT = 4;
    localparam int unsigned IDX_W      = $clog2(CHAN_COUNT);

    typedef enum logic [1:0] {
        DB_RELEASED  = 2'd0,
        DB_RISE_WAIT = 2'd1,
        DB_HELD      = 2'd2,
        DB_FALL_WAIT = 2'd3
    } db_state_t;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/chsel_debounce.sv
module chsel_debounce
    import chsel_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 65536
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic press_o
);
    localparam int unsigned      CW   = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0]    LAST = CW'(STABLE_CYCLES - 1);

    db_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          press_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_RELEASED:  if (level_i)            state_d = DB_RISE_WAIT;
            DB_RISE_WAIT: if (!level_i)           state_d = DB_RELEASED;
                          else if (cnt_q == LAST) state_d = DB_HELD;
            DB_HELD:      if (!level_i)           state_d = DB_FALL_WAIT;
            DB_FALL_WAIT: if (level_i)            state_d = DB_HELD;
                          else if (cnt_q == LAST) state_d = DB_RELEASED;
            default:                              state_d = DB_RELEASED;
        endcase
    end

    // state register and stability counter
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= DB_RELEASED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q == DB_RISE_WAIT || state_q == DB_FALL_WAIT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // output register: one pulse per accepted press
    always_ff @(posedge clk_i) begin
        if (rst_i) press_q <= 1'b0;
        else       press_q <= (state_q == DB_RISE_WAIT) && (state_d == DB_HELD);
    end

    assign press_o = press_q;

    // R7: a press event lasts exactly one clock
    a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        press_q |=> !press_q);

    // R8: an event only follows a stable high level
    a_r8_event_after_high: assert property (@(posedge clk_i) disable iff (rst_i)
        press_q |-> state_q == DB_HELD);

    // R6: a release never produces an event
    a_r6_release_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == DB_FALL_WAIT) |=> !press_q);
endmodule

// File: rtl/chsel_toggle_pair.sv
module chsel_toggle_pair (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       step_i,
    output logic [1:0] count_o
);
    logic lo_q, hi_q;

    // low stage flips on every step; high stage flips when low leaves 1
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else if (step_i) begin
            lo_q <= ~lo_q;
            if (lo_q) hi_q <= ~hi_q;
        end
    end

    assign count_o = {hi_q, lo_q};

    // R5: low stage flips on each step
    a_r5_low_flips: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i |=> lo_q != $past(lo_q));

    // R5: high stage flips only as low stage falls
    a_r5_high_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && lo_q) |=> hi_q != $past(hi_q));

    a_r5_high_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(step_i && lo_q) |=> $stable(hi_q));
endmodule

// File: rtl/chan_stepper.sv
module chan_stepper
    import chsel_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 65536,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  btn_i,
    output logic [CHAN_COUNT-1:0] sel_o,
    output logic [IDX_W-1:0]      chan_idx_o
);
    localparam logic [CHAN_COUNT-1:0] SEL_RESET = {1'b1, {(CHAN_COUNT-1){1'b0}}};

    logic                  btn_sync;
    logic                  press;
    logic [IDX_W-1:0]      count;
    logic [CHAN_COUNT-1:0] sel_d;
    logic [CHAN_COUNT-1:0] sel_q;
    logic [IDX_W-1:0]      idx_q;

    chsel_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i), .rst_i (rst_i), .async_i (btn_i), .sync_o (btn_sync)
    );

    chsel_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) i_debounce (
        .clk_i (clk_i), .rst_i (rst_i), .level_i (btn_sync), .press_o (press)
    );

    chsel_toggle_pair i_stages (
        .clk_i (clk_i), .rst_i (rst_i), .step_i (press), .count_o (count)
    );

    // NOR decode: a line is high only when every compared bit matches
    for (genvar ch = 0; ch < CHAN_COUNT; ch++) begin : g_decode
        localparam logic [IDX_W-1:0] CODE = IDX_W'(ch);
        assign sel_d[CHAN_COUNT-1-ch] = ~|(count ^ CODE);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= SEL_RESET;
            idx_q <= '0;
        end else begin
            sel_q <= sel_d;
            idx_q <= count;
        end
    end

    assign sel_o      = sel_q;
    assign chan_idx_o = idx_q;

    // R1: one line active
    a_r1_one_hot: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(sel_q) == 1);

    // R2: reset lands on channel 1
    a_r2_reset_ch1: assert property (@(posedge clk_i)
        rst_i |=> (sel_q == SEL_RESET) && (idx_q == '0));

    // R3: the outputs only move after a press event
    a_r3_step_follows_press: assert property (@(posedge clk_i) disable iff (rst_i)
        !press |=> ##1 $stable(sel_q));
endmodule

// File: tb/test_chan_stepper.sv
module test_chan_stepper;
    localparam int DEB = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic [3:0] sel;
    logic [1:0] idx;

    int checks = 0;
    int fails  = 0;
    int exp_idx = 0;
    bit finished = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    chan_stepper #(.DEBOUNCE_CYCLES(DEB)) i_chan_stepper (
        .clk_i (clk), .rst_i (rst), .btn_i (btn), .sel_o (sel), .chan_idx_o (idx)
    );

    always #4 clk = ~clk;

    function automatic logic [5:0] pattern(input int i);
        return {2'(i), 4'b1000 >> i};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual idx/sel=%b expected %b", tag, what, act, exp);
        end
    endtask

    // monitor: every change of the outputs must match the next queued item
    logic [3:0] prev_sel = 4'b1000;
    always @(negedge clk) begin
        if (rst) prev_sel <= sel;
        else begin
            if (sel !== prev_sel) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R7", "unexpected step", {idx, sel}, {idx, prev_sel});
                else begin
                    logic [5:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({idx, sel} === e && $countones(sel) == 1, t,
                          "step pattern (R1 one-hot)", {idx, sel}, e);
                end
            end
            prev_sel <= sel;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input bit bounce, input int hold, input string tag);
        exp_idx = (exp_idx + 1) % 4;
        exp_q.push_back(pattern(exp_idx));
        tag_q.push_back(tag);
        if (bounce) begin
            btn = 1; wait_cyc(2); btn = 0; wait_cyc(1);
            btn = 1; wait_cyc(3); btn = 0; wait_cyc(2);
        end
        btn = 1;
        wait_cyc(hold);
        check(exp_q.size() == 0, tag, "press produced its step", {idx, sel}, pattern(exp_idx));
        if (bounce) begin
            btn = 0; wait_cyc(2); btn = 1; wait_cyc(3); btn = 0; wait_cyc(1); btn = 1; wait_cyc(1);
        end
        btn = 0;
        wait_cyc(30);
        check({idx, sel} === pattern(exp_idx), "R6", "release left selection", {idx, sel},
              pattern(exp_idx));
    endtask

    initial begin
        wait_cyc(4);
        rst = 0;
        wait_cyc(1);
        check({idx, sel} === pattern(0), "R2", "reset state", {idx, sel}, pattern(0));

        press(0, 30, "R3");
        press(1, 30, "R8");
        press(0, 30, "R3");
        press(0, 30, "R4");
        check(sel === 4'b1000, "R4", "wrapped to channel 1", {idx, sel}, pattern(0));

        // short glitch: DEB cycles or fewer must be ignored
        btn = 1; wait_cyc(3); btn = 0; wait_cyc(30);
        check({idx, sel} === pattern(exp_idx), "R8", "glitch ignored", {idx, sel}, pattern(exp_idx));

        press(0, 400, "R7");
        press(1, 30, "R5");
        press(0, 30, "R5");
        check(idx === 2'd3, "R5", "index after three steps", {idx, sel}, pattern(3));

        // reset mid-sequence
        @(negedge clk); rst = 1; wait_cyc(3); rst = 0;
        exp_idx = 0;
        wait_cyc(1);
        check({idx, sel} === pattern(0), "R2", "reset from channel 4", {idx, sel}, pattern(0));
        press(0, 30, "R3");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule